// File: doc/BRIEF.md
# Clock Readout Sequencer with Shared-Bus Arbitration

This block fetches the current date and time from an external clock chip without help from the processor. It sits in front of a byte-wide, memory-mapped I2C controller and acts as a second master on that controller's register bus. A request starts a run, and one run is also started automatically when reset is released. During a run the block replays a short, fixed list of register operations. The list sets the device address and the register pointer, issues a multi-byte read command, polls the status register until the transfer is done, and then reads the received bytes back. The bytes are packed into a 65-bit date/time word.

The operation list is chosen at elaboration by the `BOARD` parameter. There are three variants. They differ in device address, in the chip's byte order and in the extra hold/release writes that go around the read. The processor keeps its own path to the controller. A small arbiter grants the bus to whichever master asks first, and the processor wins a same-cycle tie. Once the sequencer has made its first access, it keeps the bus until its run ends, and a blocked processor access is held off with a wait signal.

Top module: `rtc_fetch_seq`

## Requirements
- R1: One run starts on the first clock edge after reset is released, with no request needed.
- R2: A high `start_i` while idle starts a run: `busy_o` is high from the next edge until the run finishes or aborts. A `start_i` seen while `busy_o` is high is ignored.
- R3: For `BOARD`=0 a run issues these accesses, in this order:
  - write 0x51 to 0xF0 (device address);
  - write 0x00 to 0xF2 (register pointer);
  - write 0x07 to 0xF3 (read command, byte count);
  - one or more reads of the status register at 0xF1;
  - reads of the receive bytes at 0x00 through 0x06.
- R4: A status read with bit 0 (transfer busy) set repeats the same status read on the next granted cycle. The sequence does not advance until bit 0 reads 0.
- R5: Receive byte k lands in `stamp_o[8k+7:8k]`, which for `BOARD`=0 is lane k for k = 0..6. Bits 63:56 of a published word are always 0x40.
- R6: Each successful run publishes its word and inverts `stamp_o[64]` relative to the previous word. `stamp_o` changes at no other time.
- R7: A status read with bit 0 clear and bit 2 (no acknowledge) set aborts the run. `fail_o` goes high, `busy_o` goes low, `stamp_o` keeps its value, and the bus lock is released on the same edge.
- R8: `fail_o` is cleared on the edge where a new run is accepted.
- R9: Outside a locked run, a processor access (`cpu_req_i`) is passed to the controller in the same cycle with `cpu_wait_o` low. It wins over a pending sequencer access in the same cycle.
- R10: The bus is locked to the sequencer from the edge after its first granted access until the edge where its run ends. While the lock is held, `cpu_wait_o` equals `cpu_req_i` and no processor access reaches the controller.
- R11: While reset is applied, `busy_o`, `fail_o`, `cpu_wait_o` and `stamp_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a readout run |
| cpu_req_i | input | 1 | Processor access request (held until not waited) |
| cpu_we_i | input | 1 | Processor access is a write |
| cpu_addr_i | input | 8 | Processor register address |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rdata_o | output | 8 | Read data returned to the processor |
| cpu_wait_o | output | 1 | Processor access held off this cycle |
| ctl_req_o | output | 1 | Access strobe to the I2C controller |
| ctl_we_o | output | 1 | Controller access is a write |
| ctl_addr_o | output | 8 | Controller register address |
| ctl_wdata_o | output | 8 | Controller write data |
| ctl_rdata_i | input | 8 | Controller read data, valid in the access cycle |
| busy_o | output | 1 | Run in progress |
| fail_o | output | 1 | Last run aborted on no acknowledge |
| stamp_o | output | 65 | Packed date/time word with toggle bit 64 |

## Verification
Two events collide on purpose. The first collision is a processor access that arrives in the same cycle as the sequencer's first pending access. The bench raises `cpu_req_i` together with `start_i`, so the processor must be granted and the run's opening write must be deferred by one cycle. The second collision is a processor write to the device-address register, issued while the lock is held and aimed at corrupting the run, together with a `start_i` pulse that lands mid-run. Both must leave the run untouched. A behavioural model in the bench predicts every controller-side strobe, address and write flag, and also `cpu_wait_o`, `busy_o`, `fail_o` and `stamp_o`, and these are compared every cycle.

// File: rtl/rtcseq_pkg.sv
package rtcseq_pkg;

  localparam int BUS_AW      = 8;
  localparam int BUS_DW      = 8;
  localparam int LANES       = 7;
  localparam int STAMP_W     = (LANES + 1) * BUS_DW + 1;
  localparam int STEP_DEPTH  = 16;
  localparam int IDX_W       = $clog2(STEP_DEPTH);
  localparam int LANE_W      = 3;
  localparam int ST_BUSY_BIT = 0;
  localparam int ST_NACK_BIT = 2;
  localparam int READ_BYTES  = LANES;

  localparam logic [BUS_AW-1:0] A_DEV  = 8'hF0;
  localparam logic [BUS_AW-1:0] A_STAT = 8'hF1;
  localparam logic [BUS_AW-1:0] A_PTR  = 8'hF2;
  localparam logic [BUS_AW-1:0] A_CMD  = 8'hF3;
  localparam logic [BUS_AW-1:0] A_HOLD = 8'hF4;
  localparam logic [BUS_DW-1:0] STAMP_MARK = 8'h40;

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_RD   = 2'd1,
    OP_POLL = 2'd2,
    OP_END  = 2'd3
  } seq_op_e;

  typedef struct packed {
    seq_op_e           op;
    logic [BUS_AW-1:0] addr;
    logic [BUS_DW-1:0] data;
    logic [LANE_W-1:0] lane;
  } seq_step_t;

  typedef logic [LANES-1:0][BUS_DW-1:0] stage_t;

  function automatic seq_step_t mk_step(seq_op_e op, logic [BUS_AW-1:0] a,
                                        logic [BUS_DW-1:0] d, logic [LANE_W-1:0] l);
    seq_step_t s;
    s.op   = op;
    s.addr = a;
    s.data = d;
    s.lane = l;
    return s;
  endfunction

  function automatic logic [BUS_DW-1:0] dev_of(int board);
    case (board)
      1:       return 8'h68;
      2:       return 8'h6F;
      default: return 8'h51;
    endcase
  endfunction

  function automatic logic [BUS_DW-1:0] ptr_of(int board);
    return (board == 2) ? 8'h10 : 8'h00;
  endfunction

  // chip byte order -> output lane; variant 1 stores weekday before day-of-month
  function automatic logic [LANE_W-1:0] lane_of(int board, int slot);
    if (board == 1) begin
      case (slot)
        3:       return 3'd6;
        4:       return 3'd3;
        5:       return 3'd4;
        6:       return 3'd5;
        default: return LANE_W'(slot);
      endcase
    end
    return LANE_W'(slot);
  endfunction

  function automatic seq_step_t step_at(int board, int i);
    int base;
    int k;
    base = (board == 2) ? 1 : 0;
    k    = i - base;
    if (board == 2 && i == 0)
      return mk_step(OP_WR, A_HOLD, 8'h01, '0);
    if (k == 0) return mk_step(OP_WR, A_DEV, dev_of(board), '0);
    if (k == 1) return mk_step(OP_WR, A_PTR, ptr_of(board), '0);
    if (k == 2) return mk_step(OP_WR, A_CMD, BUS_DW'(READ_BYTES), '0);
    if (k == 3) return mk_step(OP_POLL, A_STAT, '0, '0);
    if (k >= 4 && k < 4 + READ_BYTES)
      return mk_step(OP_RD, BUS_AW'(k - 4), '0, lane_of(board, k - 4));
    if (board == 2 && k == 4 + READ_BYTES)
      return mk_step(OP_WR, A_HOLD, 8'h00, '0);
    return mk_step(OP_END, '0, '0, '0);
  endfunction

  function automatic logic [STAMP_W-1:0] pack_stamp(logic tog, stage_t st);
    return {tog, STAMP_MARK, st};
  endfunction

endpackage

// File: rtl/rtcseq_rom.sv
module rtcseq_rom
  import rtcseq_pkg::*;
#(
  parameter int BOARD = 0
) (
  input  logic [IDX_W-1:0] idx_i,
  output seq_step_t        step_o
);

  seq_step_t table_w [STEP_DEPTH];

  for (genvar g = 0; g < STEP_DEPTH; g++) begin : g_entry
    assign table_w[g] = step_at(BOARD, g);
  end

  assign step_o = table_w[idx_i];

endmodule

// File: rtl/rtcseq_arbiter.sv
module rtcseq_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req_i,
  input  logic seq_want_i,
  input  logic seq_acc_i,
  input  logic seq_release_i,
  output logic cpu_gnt_o,
  output logic seq_gnt_o,
  output logic lock_o
);

  logic lock_q;

  assign seq_gnt_o = seq_want_i && (lock_q || !cpu_req_i);
  assign cpu_gnt_o = cpu_req_i && !lock_q;
  assign lock_o    = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_q <= 1'b0;
    else if (lock_q)
      lock_q <= !seq_release_i;
    else
      lock_q <= seq_gnt_o && seq_acc_i && !seq_release_i;
  end

  // a run that ends frees the bus on the very next cycle
  p_lock_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_release_i |=> !lock_q);

endmodule

// File: rtl/rtcseq_engine.sv
module rtcseq_engine
  import rtcseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               gnt_i,
  input  logic [BUS_DW-1:0]  rdata_i,
  input  seq_step_t          step_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               want_o,
  output logic               acc_o,
  output logic               we_o,
  output logic [BUS_AW-1:0]  addr_o,
  output logic [BUS_DW-1:0]  wdata_o,
  output logic               release_o,
  output logic               busy_o,
  output logic               fail_o,
  output logic [STAMP_W-1:0] stamp_o
);

  logic               busy_q, boot_q, fail_q;
  logic [IDX_W-1:0]   idx_q;
  stage_t             stage_q;
  logic [STAMP_W-1:0] stamp_q;

  logic active, accept, st_busy, st_nack;
  logic poll_hold, abort_evt, finish_evt, advance, read_evt;

  assign active     = busy_q && gnt_i;
  assign accept     = !busy_q && (start_i || boot_q);
  assign st_busy    = rdata_i[ST_BUSY_BIT];
  assign st_nack    = rdata_i[ST_NACK_BIT];
  assign poll_hold  = active && step_i.op == OP_POLL && st_busy;
  assign abort_evt  = active && step_i.op == OP_POLL && !st_busy && st_nack;
  assign finish_evt = active && step_i.op == OP_END;
  assign read_evt   = active && step_i.op == OP_RD;
  assign advance    = active && (step_i.op == OP_WR || step_i.op == OP_RD ||
                                 (step_i.op == OP_POLL && !st_busy && !st_nack));

  assign idx_o     = idx_q;
  assign want_o    = busy_q;
  assign acc_o     = active && step_i.op != OP_END;
  assign we_o      = step_i.op == OP_WR;
  assign addr_o    = step_i.addr;
  assign wdata_o   = step_i.data;
  assign release_o = finish_evt || abort_evt;
  assign busy_o    = busy_q;
  assign fail_o    = fail_q;
  assign stamp_o   = stamp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      boot_q  <= 1'b1;
      fail_q  <= 1'b0;
      idx_q   <= '0;
      stage_q <= '0;
      stamp_q <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        boot_q <= 1'b0;
        fail_q <= 1'b0;
        idx_q  <= '0;
      end
      if (advance)
        idx_q <= idx_q + 1'b1;
      if (read_evt && step_i.lane < LANE_W'(LANES))
        stage_q[step_i.lane] <= rdata_i;
      if (finish_evt) begin
        busy_q  <= 1'b0;
        stamp_q <= pack_stamp(!stamp_q[STAMP_W-1], stage_q);
      end
      if (abort_evt) begin
        busy_q <= 1'b0;
        fail_q <= 1'b1;
      end
    end
  end

  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish_evt && !abort_evt) |=> busy_q);

  p_poll_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hold |=> ($stable(idx_q) && busy_q));

  p_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (stamp_q[STAMP_W-2 -: BUS_DW] == STAMP_MARK));

  p_toggle_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stamp_q != $past(stamp_q)) |-> (stamp_q[STAMP_W-1] != $past(stamp_q[STAMP_W-1])));

  p_abort_keeps_stamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> ($stable(stamp_q) && fail_q && !busy_q));

endmodule

// File: rtl/rtc_fetch_seq.sv
module rtc_fetch_seq
  import rtcseq_pkg::*;
#(
  parameter int BOARD = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               cpu_req_i,
  input  logic               cpu_we_i,
  input  logic [BUS_AW-1:0]  cpu_addr_i,
  input  logic [BUS_DW-1:0]  cpu_wdata_i,
  output logic [BUS_DW-1:0]  cpu_rdata_o,
  output logic               cpu_wait_o,
  output logic               ctl_req_o,
  output logic               ctl_we_o,
  output logic [BUS_AW-1:0]  ctl_addr_o,
  output logic [BUS_DW-1:0]  ctl_wdata_o,
  input  logic [BUS_DW-1:0]  ctl_rdata_i,
  output logic               busy_o,
  output logic               fail_o,
  output logic [STAMP_W-1:0] stamp_o
);

  seq_step_t          step_w;
  logic [IDX_W-1:0]   idx_w;
  logic               want_w, acc_w, swe_w, rel_w;
  logic [BUS_AW-1:0]  saddr_w;
  logic [BUS_DW-1:0]  swdata_w;
  logic               cpu_gnt_w, seq_gnt_w, lock_w, busy_w;
  logic               seq_drive;

  rtcseq_rom #(.BOARD(BOARD)) u_rom (
    .idx_i  (idx_w),
    .step_o (step_w)
  );

  rtcseq_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .gnt_i     (seq_gnt_w),
    .rdata_i   (ctl_rdata_i),
    .step_i    (step_w),
    .idx_o     (idx_w),
    .want_o    (want_w),
    .acc_o     (acc_w),
    .we_o      (swe_w),
    .addr_o    (saddr_w),
    .wdata_o   (swdata_w),
    .release_o (rel_w),
    .busy_o    (busy_w),
    .fail_o    (fail_o),
    .stamp_o   (stamp_o)
  );

  rtcseq_arbiter u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_i     (cpu_req_i),
    .seq_want_i    (want_w),
    .seq_acc_i     (acc_w),
    .seq_release_i (rel_w),
    .cpu_gnt_o     (cpu_gnt_w),
    .seq_gnt_o     (seq_gnt_w),
    .lock_o        (lock_w)
  );

  assign seq_drive   = seq_gnt_w && acc_w;
  assign ctl_req_o   = cpu_gnt_w || seq_drive;
  assign ctl_we_o    = seq_drive ? swe_w    : cpu_we_i;
  assign ctl_addr_o  = seq_drive ? saddr_w  : cpu_addr_i;
  assign ctl_wdata_o = seq_drive ? swdata_w : cpu_wdata_i;
  assign cpu_rdata_o = ctl_rdata_i;
  assign cpu_wait_o  = cpu_req_i && !cpu_gnt_w;
  assign busy_o      = busy_w;

  // the arbiter lock only ever exists inside a sequencer run
  p_lock_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_w |-> busy_w);

  // an idle sequencer never touches the controller
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !seq_drive);

endmodule

// File: tb/tb_rtc_fetch_seq.sv
`timescale 1ns/1ps
module tb_rtc_fetch_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0, cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_wait;
  logic        ctl_req, ctl_we;
  logic [7:0]  ctl_addr, ctl_wdata;
  logic [7:0]  ctl_rdata;
  logic        busy, fail;
  logic [64:0] stamp;

  always #2 clk = ~clk;

  rtc_fetch_seq #(.BOARD(0)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_wait_o(cpu_wait),
    .ctl_req_o(ctl_req), .ctl_we_o(ctl_we), .ctl_addr_o(ctl_addr),
    .ctl_wdata_o(ctl_wdata), .ctl_rdata_i(ctl_rdata),
    .busy_o(busy), .fail_o(fail), .stamp_o(stamp)
  );

  int compared = 0, mismatched = 0;
  task automatic chk(string tag, logic [64:0] act, logic [64:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- controller model ----------------
  logic [7:0] chip_mem [16];
  logic [7:0] rxb [8];
  logic [7:0] c_dev = 8'h00, c_ptr = 8'h00;
  int         c_cnt = 0;
  logic       c_nack = 1'b0;
  logic       absent = 1'b0;

  function automatic logic [7:0] c_read(logic [7:0] a);
    if (a == 8'hF1) return {5'b0, c_nack, 1'b0, (c_cnt != 0)};
    if (a == 8'hF0) return c_dev;
    if (a == 8'hF2) return c_ptr;
    if (a < 8'd8)   return rxb[a[2:0]];
    return 8'h00;
  endfunction

  always_comb begin
    ctl_rdata = 8'h00;
    if (ctl_addr == 8'hF1)      ctl_rdata = {5'b0, c_nack, 1'b0, (c_cnt != 0)};
    else if (ctl_addr == 8'hF0) ctl_rdata = c_dev;
    else if (ctl_addr == 8'hF2) ctl_rdata = c_ptr;
    else if (ctl_addr < 8'd8)   ctl_rdata = rxb[ctl_addr[2:0]];
  end

  always @(posedge clk) begin
    if (c_cnt > 0) c_cnt <= c_cnt - 1;
    if (ctl_req && ctl_we) begin
      if (ctl_addr == 8'hF0) c_dev <= ctl_wdata;
      if (ctl_addr == 8'hF2) c_ptr <= ctl_wdata;
      if (ctl_addr == 8'hF3) begin
        c_cnt  <= 3;
        c_nack <= absent || (c_dev != 8'h51);
        for (int i = 0; i < 7; i++)
          rxb[i] <= (absent || c_dev != 8'h51) ? 8'hFF : chip_mem[(c_ptr + i) & 15];
      end
    end
  end

  // ---------------- reference model of the block ----------------
  // op codes: 0 write, 1 read, 2 poll, 3 end
  int t_op [12];
  int t_adr[12];
  int t_dat[12];
  int t_ln [12];

  logic        m_busy, m_boot, m_fail, m_lock;
  int          m_idx;
  logic [7:0]  m_lane [7];
  logic [64:0] m_stamp;
  logic        m_live = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_boot = 1; m_fail = 0; m_lock = 0; m_idx = 0;
      m_stamp = '0;
      for (int i = 0; i < 7; i++) m_lane[i] = 8'h00;
      m_live = 1'b1;
    end else if (m_busy) begin
      if (m_lock || !cpu_req) begin
        logic rel;
        logic [7:0] s;
        rel = 1'b0;
        case (t_op[m_idx])
          0: m_idx++;
          1: begin m_lane[t_ln[m_idx]] = c_read(8'(t_adr[m_idx])); m_idx++; end
          2: begin
            s = c_read(8'(t_adr[m_idx]));
            if (s[0]) ;
            else if (s[2]) begin m_fail = 1; m_busy = 0; rel = 1; end
            else m_idx++;
          end
          default: begin
            m_stamp[64] = ~m_stamp[64];
            m_stamp[63:56] = 8'h40;
            for (int i = 0; i < 7; i++) m_stamp[8*i +: 8] = m_lane[i];
            m_busy = 0; rel = 1;
          end
        endcase
        m_lock = !rel;
      end
    end else if (start || m_boot) begin
      m_busy = 1; m_boot = 0; m_fail = 0; m_idx = 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (m_live) begin
      logic sacc, cacc;
      sacc = m_busy && (m_lock || !cpu_req) && t_op[m_idx] != 3;
      cacc = cpu_req && !m_lock;
      chk("R2 busy", busy, m_busy);
      chk("R7 fail", fail, m_fail);
      chk("R5 stamp", stamp, m_stamp);
      chk("R10 cpu_wait", cpu_wait, cpu_req && m_lock);
      chk("R3 ctl_req", ctl_req, sacc || cacc);
      if (sacc || cacc) begin
        chk("R3 ctl_addr", ctl_addr, sacc ? 8'(t_adr[m_idx]) : cpu_addr);
        chk("R3 ctl_we", ctl_we, sacc ? (t_op[m_idx] == 0) : cpu_we);
        if (sacc && t_op[m_idx] == 0) chk("R3 ctl_wdata", ctl_wdata, 8'(t_dat[m_idx]));
      end
    end
  end

  int poll_cnt = 0;
  always @(posedge clk)
    if (ctl_req && !ctl_we && ctl_addr == 8'hF1) poll_cnt <= poll_cnt + 1;

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog expired act=%0d exp=<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 300) begin tick(1); n++; end
  endtask

  function automatic logic [64:0] expect_word(logic tog);
    logic [64:0] w;
    w[64] = tog; w[63:56] = 8'h40;
    for (int i = 0; i < 7; i++) w[8*i +: 8] = chip_mem[i];
    return w;
  endfunction

  logic [64:0] saved;

  initial begin
    for (int i = 0; i < 16; i++) chip_mem[i] = 8'(i);
    chip_mem[0] = 8'h45; chip_mem[1] = 8'h30; chip_mem[2] = 8'h12;
    chip_mem[3] = 8'h25; chip_mem[4] = 8'h06; chip_mem[5] = 8'h24; chip_mem[6] = 8'h03;
    for (int i = 0; i < 8; i++) rxb[i] = 8'h00;
    t_op[0] = 0; t_adr[0] = 'hF0; t_dat[0] = 'h51; t_ln[0] = 0;
    t_op[1] = 0; t_adr[1] = 'hF2; t_dat[1] = 'h00; t_ln[1] = 0;
    t_op[2] = 0; t_adr[2] = 'hF3; t_dat[2] = 'h07; t_ln[2] = 0;
    t_op[3] = 2; t_adr[3] = 'hF1; t_dat[3] = 0;    t_ln[3] = 0;
    for (int i = 0; i < 7; i++) begin
      t_op[4+i] = 1; t_adr[4+i] = i; t_dat[4+i] = 0; t_ln[4+i] = i;
    end
    t_op[11] = 3; t_adr[11] = 0; t_dat[11] = 0; t_ln[11] = 0;

    tick(3);
    // R11 reset state
    chk("R11 busy in reset", busy, 1'b0);
    chk("R11 fail in reset", fail, 1'b0);
    chk("R11 wait in reset", cpu_wait, 1'b0);
    chk("R11 stamp in reset", stamp, 65'd0);
    poll_cnt = 0;
    rst_n = 1'b1;
    tick(1);
    chk("R1 auto run after reset", busy, 1'b1);
    wait_idle();
    chk("R4 status polled until idle", 65'(poll_cnt), 65'd4);
    chk("R5 lanes and marker", stamp, expect_word(1'b1));

    // run 2: tie with processor, blocked write, ignored start
    chip_mem[0] = 8'h46;
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'hF1; start = 1;
    tick(1);
    start = 0;
    chk("R9 cpu wins tie", cpu_wait, 1'b0);
    chk("R9 cpu address to controller", ctl_addr, 8'hF1);
    tick(1);
    cpu_req = 0;
    tick(2);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'hF0; cpu_wdata = 8'h77;
    #1;
    chk("R10 cpu held while locked", cpu_wait, 1'b1);
    tick(1);
    start = 1;
    tick(1);
    start = 0;
    chk("R2 start while busy ignored", busy, 1'b1);
    tick(2);
    cpu_req = 0; cpu_we = 0;
    wait_idle();
    chk("R6 toggle flips, value new", stamp, expect_word(1'b0));

    // run 3: absent device
    saved = stamp;
    absent = 1; start = 1;
    tick(1);
    start = 0;
    wait_idle();
    chk("R7 fail raised", fail, 1'b1);
    chk("R7 stamp kept", stamp, saved);
    cpu_req = 1; cpu_addr = 8'hF0;
    #1;
    chk("R7 lock released", cpu_wait, 1'b0);
    tick(1);
    cpu_req = 0;

    // run 4: recovery
    absent = 0; chip_mem[1] = 8'h31; start = 1;
    tick(1);
    start = 0;
    chk("R8 fail cleared on accept", fail, 1'b0);
    wait_idle();
    chk("R6 toggle flips again", stamp, expect_word(1'b1));
    tick(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule